// File: doc/BRIEF.md
# Framed Asynchronous Serial Transmitter with Line Break

The block turns one character from a host into a framed asynchronous bit stream on a single serial output. It runs entirely on a transmit clock input and updates its output register only on the falling edge of that clock. Each frame has the form: a low start bit, then 5 to 8 data bits with the least significant bit first, then an optional wake-up bit, then an optional parity bit, then one or two high stop bits. One bit lasts 1, 16, 32 or 64 transmit-clock periods.

The host hands over characters through a valid/ready pair. A transfer happens at a falling edge of `clk` at which `wr_valid` and `wr_ready` are both high. The host keeps `wr_valid` and `wr_data` steady until that edge. The block applies back-pressure by holding `wr_ready` low while a frame is on the line and while a break is requested. The framing controls and the rate select are sampled at the transfer edge, so changing them mid-frame does not affect the frame in progress. While nothing is being sent, the line rests high. A break request drives the line low until the request is removed. If the request arrives during a frame, that frame is abandoned at the next bit boundary.

Top module: `sertx`

## Requirements
- R1: After reset, while `brk` is low, `txd` is high and `wr_ready` is high.
- R2: A transfer takes place at a falling edge with `wr_valid` and `wr_ready` both high. `txd` goes low (the start bit) at that same edge. `wr_ready` is low whenever a frame is in progress.
- R3: The data bits follow the start bit, least significant bit first. Their count is set by `char_len`: 00=5, 01=6, 10=7, 11=8. Written bits above that count never appear on the line.
- R4: When `wake_en` is 1, one extra bit equal to `wake_bit` is sent directly after the last data bit.
- R5: When `par_en` is 1, a parity bit follows the data bits and, if enabled, the wake-up bit. It is computed over the data bits only. With `par_even`=1, the data bits plus the parity bit hold an even number of ones; with `par_even`=0, an odd number.
- R6: The frame ends with high stop bits: one when `two_stop` is 0, two when it is 1.
- R7: Each bit lasts 1, 16, 32 or 64 clock periods for `rate_sel` 00, 01, 10, 11. The rate and framing controls are captured at the transfer edge.
- R8: `txd` changes only on falling edges of `clk`.
- R9: When no frame is in progress and no break is requested, `txd` is high. After the final stop bit, `wr_ready` rises again.
- R10: When `brk` is high with no frame in progress, `txd` is low from the next falling edge and stays low while `brk` stays high. `wr_ready` is low during that time and a held `wr_valid` is ignored.
- R11: When `brk` rises during a frame, the line keeps the current bit until that bit's time ends. From then on `txd` is low and the rest of the frame is dropped. `txd` returns high at the first falling edge after `brk` is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit clock; all state updates on its falling edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Host offers a character |
| wr_ready | output | 1 | Block can take a character |
| wr_data | input | 8 | Character, bit 0 sent first |
| char_len | input | 2 | Data bit count: 00=5, 01=6, 10=7, 11=8 |
| par_en | input | 1 | Append a parity bit |
| par_even | input | 1 | 1 = even parity, 0 = odd parity |
| two_stop | input | 1 | 1 = two stop bits, 0 = one |
| wake_en | input | 1 | Append a wake-up bit after the data |
| wake_bit | input | 1 | Value of the wake-up bit |
| rate_sel | input | 2 | Clocks per bit: 00=1, 01=16, 10=32, 11=64 |
| brk | input | 1 | Break request: hold the line low |
| txd | output | 1 | Serial output |

## Verification
A corrupted shift register or bit counter shows up on `txd` as a wrong bit or a frame of the wrong length. It is seen within one bit time of the fault, at most 64 clocks. A stuck busy flag shows up immediately as `wr_ready` disagreeing with the idle line. A divider counting to the wrong limit stretches or shortens the very first start bit. For these reasons the bench compares `txd` and `wr_ready` against a behavioural queue model on every clock, and it checks separately that `txd` holds still across each rising edge.

// File: rtl/sertx_pkg.sv
package sertx_pkg;
  localparam int DATA_W  = 8;
  localparam int MIN_LEN = DATA_W - 3;
  // start + data + wake + parity + two stops
  localparam int FRAME_W = DATA_W + 5;
  localparam int LEN_W   = $clog2(FRAME_W + 1);

  typedef enum logic [1:0] {
    RATE_X1  = 2'd0,
    RATE_X16 = 2'd1,
    RATE_X32 = 2'd2,
    RATE_X64 = 2'd3
  } rate_e;

  typedef struct packed {
    logic [1:0] char_len;
    logic       par_en;
    logic       par_even;
    logic       two_stop;
    logic       wake_en;
    logic       wake_bit;
  } frame_cfg_t;
endpackage

// File: rtl/sertx_frame_build.sv
module sertx_frame_build
  import sertx_pkg::*;
(
  input  logic [DATA_W-1:0]  data,
  input  frame_cfg_t         cfg,
  output logic [FRAME_W-1:0] frame,
  output logic [LEN_W-1:0]   nbits
);
  logic [LEN_W-1:0] clen;
  logic [LEN_W-1:0] pos;
  logic             par;

  always_comb begin
    clen  = LEN_W'(MIN_LEN) + LEN_W'(cfg.char_len);
    frame = '1;
    frame[0] = 1'b0;
    par   = 1'b0;
    pos   = LEN_W'(1);
    for (int i = 0; i < DATA_W; i++) begin
      if (LEN_W'(i) < clen) begin
        frame[pos] = data[i];
        par        = par ^ data[i];
        pos        = pos + LEN_W'(1);
      end
    end
    if (cfg.wake_en) begin
      frame[pos] = cfg.wake_bit;
      pos        = pos + LEN_W'(1);
    end
    if (cfg.par_en) begin
      frame[pos] = cfg.par_even ? par : ~par;
      pos        = pos + LEN_W'(1);
    end
    nbits = pos + (cfg.two_stop ? LEN_W'(2) : LEN_W'(1));
  end
endmodule

// File: rtl/sertx_rate_div.sv
module sertx_rate_div
  import sertx_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  restart,
  input  logic  run,
  input  rate_e rate_sel,
  output logic  tick
);
  rate_e            rate_q;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lim;

  always_comb begin
    case (rate_q)
      RATE_X1:  lim = '0;
      RATE_X16: lim = CNT_W'(15);
      RATE_X32: lim = CNT_W'(31);
      default:  lim = CNT_W'(63);
    endcase
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      rate_q <= RATE_X1;
    end else if (restart) begin
      cnt    <= '0;
      rate_q <= rate_sel;
    end else if (run) begin
      cnt <= (cnt == lim) ? '0 : cnt + 1'b1;
    end
  end

  assign tick = run && (cnt == lim);

  AST_CNT_BOUND: assert property (@(negedge clk) disable iff (!rst_n) cnt <= lim) else $error("bit counter beyond limit"); // R7
endmodule

// File: rtl/sertx_line.sv
module sertx_line
  import sertx_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [FRAME_W-1:0] frame,
  input  logic [LEN_W-1:0]   nbits,
  input  logic               tick,
  input  logic               brk,
  output logic               busy,
  output logic               txd
);
  logic [FRAME_W-1:0] sh;
  logic [LEN_W-1:0]   left;

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh   <= '1;
      left <= '0;
      busy <= 1'b0;
      txd  <= 1'b1;
    end else if (load) begin
      sh   <= frame >> 1;
      left <= nbits - LEN_W'(1);
      busy <= 1'b1;
      txd  <= frame[0];
    end else if (busy) begin
      if (tick) begin
        if (brk) begin
          busy <= 1'b0;
          txd  <= 1'b0;
        end else if (left == '0) begin
          busy <= 1'b0;
          txd  <= 1'b1;
        end else begin
          txd  <= sh[0];
          sh   <= sh >> 1;
          left <= left - LEN_W'(1);
        end
      end
    end else begin
      txd <= ~brk;
    end
  end

  AST_START_LOW: assert property (@(negedge clk) disable iff (!rst_n) load |=> (busy && !txd)) else $error("start bit missing"); // R2
  AST_HOLD_BIT: assert property (@(negedge clk) disable iff (!rst_n) (busy && !tick) |=> $stable(txd)) else $error("bit changed mid-bit"); // R7
  AST_IDLE_HIGH: assert property (@(negedge clk) disable iff (!rst_n) (!busy && !brk && !load) |=> txd) else $error("idle line not high"); // R9
  AST_BREAK_LOW: assert property (@(negedge clk) disable iff (!rst_n) (!busy && brk) |=> !txd) else $error("break not low"); // R10
  AST_BREAK_AT_EDGE: assert property (@(negedge clk) disable iff (!rst_n) (busy && tick && brk) |=> (!busy && !txd)) else $error("break not applied at boundary"); // R11
endmodule

// File: rtl/sertx.sv
module sertx
  import sertx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_valid,
  output logic       wr_ready,
  input  logic [7:0] wr_data,
  input  logic [1:0] char_len,
  input  logic       par_en,
  input  logic       par_even,
  input  logic       two_stop,
  input  logic       wake_en,
  input  logic       wake_bit,
  input  logic [1:0] rate_sel,
  input  logic       brk,
  output logic       txd
);
  frame_cfg_t         cfg;
  logic [FRAME_W-1:0] frame;
  logic [LEN_W-1:0]   nbits;
  logic               busy;
  logic               tick;
  logic               load;

  assign cfg = '{char_len: char_len, par_en: par_en, par_even: par_even,
                 two_stop: two_stop, wake_en: wake_en, wake_bit: wake_bit};

  assign wr_ready = !busy && !brk;
  assign load     = wr_valid && wr_ready;

  sertx_frame_build u_build (
    .data  (wr_data),
    .cfg   (cfg),
    .frame (frame),
    .nbits (nbits)
  );

  sertx_rate_div #(.CNT_W(6)) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .restart  (load),
    .run      (busy),
    .rate_sel (rate_e'(rate_sel)),
    .tick     (tick)
  );

  sertx_line u_line (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (load),
    .frame (frame),
    .nbits (nbits),
    .tick  (tick),
    .brk   (brk),
    .busy  (busy),
    .txd   (txd)
  );

  AST_NO_READY_IN_FRAME: assert property (@(negedge clk) disable iff (!rst_n) load |=> !wr_ready) else $error("ready during frame"); // R2
endmodule

// File: tb/sertx_bench.sv
`timescale 1ns/1ps
module sertx_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_valid = 1'b0;
  logic       wr_ready;
  logic [7:0] wr_data = 8'h00;
  logic [1:0] char_len = 2'b11;
  logic       par_en = 1'b0, par_even = 1'b0, two_stop = 1'b0;
  logic       wake_en = 1'b0, wake_bit = 1'b0;
  logic [1:0] rate_sel = 2'b00;
  logic       brk = 1'b0;
  logic       txd;

  int    checks = 0;
  int    errors = 0;
  int    cyc = 0;
  string cur_req = "R1";

  sertx u_sertx (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_data(wr_data), .char_len(char_len), .par_en(par_en), .par_even(par_even),
    .two_stop(two_stop), .wake_en(wake_en), .wake_bit(wake_bit),
    .rate_sel(rate_sel), .brk(brk), .txd(txd)
  );

  always #10 clk = ~clk;

  // behavioural reference: queue of pending bits, hold count for the current one
  bit   q[$];
  int   hold = 0;
  int   m_per = 1;
  logic m_txd = 1'b1;

  function automatic int per_of(input logic [1:0] r);
    case (r)
      2'b00: return 1;
      2'b01: return 16;
      2'b10: return 32;
      default: return 64;
    endcase
  endfunction

  task automatic build_frame();
    int n;
    int ones;
    n = 5 + int'(char_len);
    ones = 0;
    q.delete();
    q.push_back(1'b0);
    for (int i = 0; i < n; i++) begin
      q.push_back(wr_data[i]);
      if (wr_data[i]) ones++;
    end
    if (wake_en) q.push_back(wake_bit);
    if (par_en) q.push_back(par_even ? bit'(ones % 2) : bit'(1 - ones % 2));
    q.push_back(1'b1);
    if (two_stop) q.push_back(1'b1);
  endtask

  always @(negedge clk) begin
    if (!rst_n) begin
      q.delete();
      hold = 0;
      m_txd = 1'b1;
    end else if (q.size() != 0) begin
      hold--;
      if (hold == 0) begin
        if (brk) begin
          q.delete();
          m_txd = 1'b0;
        end else begin
          void'(q.pop_front());
          if (q.size() == 0) m_txd = 1'b1;
          else begin
            m_txd = q[0];
            hold = m_per;
          end
        end
      end
    end else if (wr_valid && !brk) begin
      build_frame();
      m_per = per_of(rate_sel);
      hold = m_per;
      m_txd = q[0];
    end else begin
      m_txd = !brk;
    end
  end

  // cycle-by-cycle comparison at the rising edge, plus R8 stability check
  always @(posedge clk) begin
    if (rst_n) begin
      logic exp_rdy;
      logic t0;
      exp_rdy = (q.size() == 0) && !brk;
      checks++;
      if (txd !== m_txd) begin
        errors++;
        $display("FAIL %s: txd=%0b expected %0b at cycle %0d", cur_req, txd, m_txd, cyc);
      end
      checks++;
      if (wr_ready !== exp_rdy) begin
        errors++;
        $display("FAIL %s: wr_ready=%0b expected %0b at cycle %0d", cur_req, wr_ready, exp_rdy, cyc);
      end
      t0 = txd;
      #5;
      checks++;
      if (txd !== t0) begin
        errors++;
        $display("FAIL R8: txd=%0b expected %0b (changed off the falling edge)", txd, t0);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog: cycles=%0d expected below %0d", cyc, 150000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input logic act, input logic exp, input string req, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: %s=%0b expected %0b", req, what, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #1;
  endtask

  task automatic send(input logic [7:0] d, input logic [1:0] cl, input logic pe,
                      input logic pev, input logic ts, input logic we, input logic wb,
                      input logic [1:0] rs);
    @(posedge clk);
    while (!wr_ready) @(posedge clk);
    #1;
    wr_data = d; char_len = cl; par_en = pe; par_even = pev;
    two_stop = ts; wake_en = we; wake_bit = wb; rate_sel = rs;
    wr_valid = 1'b1;
    @(posedge clk);
    #1;
    wr_valid = 1'b0;
  endtask

  task automatic wait_done();
    @(posedge clk);
    while (!wr_ready) @(posedge clk);
    #1;
  endtask

  initial begin
    idle(2);
    // R1: reset state
    chk(txd, 1'b1, "R1", "txd in reset");
    chk(wr_ready, 1'b1, "R1", "wr_ready in reset");
    rst_n = 1'b1;
    idle(3);
    chk(txd, 1'b1, "R9", "idle txd");

    cur_req = "R3";   // 8 data bits, LSB first, x1
    send(8'hA5, 2'b11, 0, 0, 0, 0, 0, 2'b00); wait_done();
    cur_req = "R6";   // two stop bits
    send(8'h3C, 2'b11, 0, 0, 1, 0, 0, 2'b00); wait_done();
    cur_req = "R3";   // 5-bit char, upper bits set must not appear
    send(8'hE6, 2'b00, 0, 0, 0, 0, 0, 2'b01); wait_done();
    cur_req = "R5";   // 6-bit even parity
    send(8'hD7, 2'b01, 1, 1, 0, 0, 0, 2'b00); wait_done();
    cur_req = "R5";   // 7-bit odd parity, two stops, x32
    send(8'h95, 2'b10, 1, 0, 1, 0, 0, 2'b10); wait_done();
    cur_req = "R4";   // wake bit then parity
    send(8'h0F, 2'b11, 1, 1, 0, 1, 1, 2'b00); wait_done();
    send(8'hF0, 2'b11, 0, 0, 0, 1, 0, 2'b00); wait_done();
    cur_req = "R7";   // x64 with controls changed mid-frame
    send(8'h5A, 2'b11, 1, 0, 0, 0, 0, 2'b11);
    rate_sel = 2'b00; char_len = 2'b00; par_en = 1'b0;
    idle(10);
    chk(txd, 1'b0, "R7", "start bit still on line at x64");
    wait_done();

    cur_req = "R2";   // back-to-back with valid held
    @(posedge clk); #1;
    wr_data = 8'h81; char_len = 2'b11; par_en = 0; two_stop = 0; wake_en = 0; rate_sel = 2'b00;
    wr_valid = 1'b1;
    idle(40);
    wr_valid = 1'b0;
    wait_done();

    cur_req = "R10";  // break while idle, held valid ignored
    brk = 1'b1; wr_valid = 1'b1;
    idle(20);
    chk(txd, 1'b0, "R10", "txd during break");
    chk(wr_ready, 1'b0, "R10", "wr_ready during break");
    wr_valid = 1'b0;
    idle(2);
    brk = 1'b0;
    idle(2);
    chk(txd, 1'b1, "R10", "txd after break cleared");
    chk(wr_ready, 1'b1, "R10", "no frame started by held write");

    cur_req = "R11";  // break in the middle of a x16 frame
    send(8'h00, 2'b11, 1, 1, 1, 0, 0, 2'b01);
    idle(40);
    brk = 1'b1;
    idle(40);
    chk(txd, 1'b0, "R11", "txd after mid-frame break");
    brk = 1'b0;
    idle(2);
    chk(txd, 1'b1, "R11", "txd after break cleared");
    chk(wr_ready, 1'b1, "R11", "frame abandoned");

    cur_req = "R9";
    send(8'h6B, 2'b10, 1, 1, 0, 1, 1, 2'b01); wait_done();
    idle(5);
    chk(txd, 1'b1, "R9", "idle after final frame");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule